// File: doc/BRIEF.md
# Miss-Wait Operand Scoreboard

This block keeps, for every physical register, a truly-ready flag together with a "waiting on a long miss" flag and a small tag. The tag names the per-miss dependence vector that a later stage uses to release waiting instructions. A load that misses the data cache marks its destination as waiting and attaches the vector tag allocated for that miss. Rename reads all three fields through a set of read ports, in the same place where it reads ready bits today.

The issue stage presents one selected candidate with up to `NUM_SRC` sources. The scoreboard classifies each source as truly ready, waiting, or blocked. If no source is blocked, at least one source is waiting and the candidate is not fully ready, the candidate is *pretend ready*: it raises a request like any ready instruction. If select then grants it, the scoreboard signals a divert instead of an execution. It also gives the tag of the lowest-numbered waiting source. The diverted instruction's destination inherits the waiting state and that tag, so consumers further down the chain are diverted in turn.

Miss completion makes the missed register ready and clears its waiting flag. Reinsertion of an instruction clears only the waiting flag of its destination, so the instruction can be judged again against misses still pending. Rename allocation returns a register to not-ready, not-waiting. Normal writeback sets ready.

Top module: `miss_wait_scoreboard`

## Requirements
- R1: After a synchronous active-low reset every register reads ready=1, waiting=0, tag=0.
- R2: A miss event on register p sets the waiting flag of p and stores the given tag. It leaves p's ready flag unchanged.
- R3: A source with its enable low counts as ready. An enabled source counts as ready if its register is ready, as waiting if it is not ready and its waiting flag is set, and as blocked otherwise. `cand_req` is 1 when every source is ready, or when none is blocked and at least one is waiting. `cand_pretend` is 1 only in the second case.
- R4: `divert` equals `cand_grant` AND `cand_pretend`. A grant of a truly ready candidate changes no scoreboard state.
- R5: A divert with `cand_dst_en` high sets the waiting flag of `cand_dst_preg` and stores `divert_vec` as its tag from the next cycle on.
- R6: `divert_vec` is the tag of the lowest-numbered waiting source. Source 0 is examined first.
- R7: Each read port returns, in the same cycle, the ready flag, waiting flag and tag of its selected register as they stood after the most recent clock edge.
- R8: A miss-completion event on p sets p ready and clears p's waiting flag.
- R9: A reinsertion event on p clears p's waiting flag and leaves its ready flag and tag unchanged.
- R10: An allocation event on p clears both ready and waiting. A writeback event on p sets ready.
- R11: When a set and a clear of the same flag of one register occur in the same cycle, the set wins. When a miss and a divert write the same register's tag in one cycle, the miss tag is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Rename allocates a destination register |
| alloc_preg | input | PREG_W | Allocated register |
| wb_valid | input | 1 | Normal result writeback |
| wb_preg | input | PREG_W | Written-back register |
| miss_valid | input | 1 | Load missed in the data cache |
| miss_preg | input | PREG_W | Destination of the missing load |
| miss_vec | input | VEC_W | Dependence-vector tag allocated for the miss |
| fill_valid | input | 1 | Miss data returned |
| fill_preg | input | PREG_W | Register filled by the returning miss |
| reins_valid | input | 1 | An instruction was reinserted into the issue queue |
| reins_preg | input | PREG_W | Destination of the reinserted instruction |
| rd_preg | input | NUM_RD*PREG_W | Rename read-port register selects, port k in bits k*PREG_W upward |
| rd_ready | output | NUM_RD | Ready flag per read port |
| rd_wait | output | NUM_RD | Waiting flag per read port |
| rd_vec | output | NUM_RD*VEC_W | Tag per read port |
| cand_src_en | input | NUM_SRC | Source used, per source of the issue candidate |
| cand_src_preg | input | NUM_SRC*PREG_W | Source registers of the candidate |
| cand_dst_en | input | 1 | Candidate writes a destination |
| cand_dst_preg | input | PREG_W | Candidate destination register |
| cand_grant | input | 1 | Select picked the candidate this cycle |
| cand_req | output | 1 | Candidate may compete in select |
| cand_pretend | output | 1 | Candidate is pretend ready |
| divert | output | 1 | Granted candidate goes to the miss buffer |
| divert_vec | output | VEC_W | Tag attached to the diverted instruction |

## Verification
On every cycle, assertions check the state transitions that follow each event: miss marking, divert propagation to the destination, miss completion, the ready flag kept across reinsertion, and allocation clearing. They also check that a divert always names a source that the storage reports as waiting. The bench alone can show the full classification of mixed source states, the source-order choice of tag, the transitive spread of waiting through a chain of dependents, and the set-over-clear rule when events collide on one register. It runs those as directed cases and under long random event streams compared with a reference model.

// File: rtl/wsb_pkg.sv
// Shared types for the miss-wait scoreboard.
// Assumes: a source is classified into exactly one of three states.
package wsb_pkg;
    typedef enum logic [1:0] {
        SRC_BLOCKED = 2'd0,
        SRC_READY   = 2'd1,
        SRC_WAITING = 2'd2
    } src_state_e;
endpackage

// File: rtl/wsb_entry_array.sv
// Per-register ready / waiting / tag storage with all event updates.
// Assumes: at most one event of each kind per cycle; sets beat clears,
// and a miss tag beats a divert tag on the same register.
module wsb_entry_array #(
    parameter int NUM_PREGS = 64,
    parameter int VEC_W     = 3,
    localparam int PREG_W   = $clog2(NUM_PREGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_valid,
    input  logic [PREG_W-1:0]          alloc_preg,
    input  logic                       wb_valid,
    input  logic [PREG_W-1:0]          wb_preg,
    input  logic                       miss_valid,
    input  logic [PREG_W-1:0]          miss_preg,
    input  logic [VEC_W-1:0]           miss_vec,
    input  logic                       fill_valid,
    input  logic [PREG_W-1:0]          fill_preg,
    input  logic                       reins_valid,
    input  logic [PREG_W-1:0]          reins_preg,
    input  logic                       div_set,
    input  logic [PREG_W-1:0]          div_preg,
    input  logic [VEC_W-1:0]           div_vec,
    output logic [NUM_PREGS-1:0]       ready_vec,
    output logic [NUM_PREGS-1:0]       wait_vec,
    output logic [NUM_PREGS*VEC_W-1:0] tag_flat
);
    logic [NUM_PREGS-1:0] ready_q, ready_d;
    logic [NUM_PREGS-1:0] wait_q,  wait_d;
    logic [VEC_W-1:0]     tag_q [NUM_PREGS];
    logic [VEC_W-1:0]     tag_d [NUM_PREGS];

    // Next-state per register: set events first, then clears, else hold.
    always_comb begin
        for (int i = 0; i < NUM_PREGS; i++) begin
            logic hit_alloc, hit_wb, hit_miss, hit_fill, hit_reins, hit_div;
            hit_alloc = alloc_valid && (alloc_preg == PREG_W'(i));
            hit_wb    = wb_valid    && (wb_preg    == PREG_W'(i));
            hit_miss  = miss_valid  && (miss_preg  == PREG_W'(i));
            hit_fill  = fill_valid  && (fill_preg  == PREG_W'(i));
            hit_reins = reins_valid && (reins_preg == PREG_W'(i));
            hit_div   = div_set     && (div_preg   == PREG_W'(i));

            if (hit_wb || hit_fill)      ready_d[i] = 1'b1;
            else if (hit_alloc)          ready_d[i] = 1'b0;
            else                         ready_d[i] = ready_q[i];

            if (hit_miss || hit_div)                       wait_d[i] = 1'b1;
            else if (hit_fill || hit_reins || hit_alloc)   wait_d[i] = 1'b0;
            else                                           wait_d[i] = wait_q[i];

            if (hit_miss)      tag_d[i] = miss_vec;
            else if (hit_div)  tag_d[i] = div_vec;
            else               tag_d[i] = tag_q[i];
        end
    end

    // State registers with synchronous reset to all-ready, nothing waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= '1;
            wait_q  <= '0;
            for (int i = 0; i < NUM_PREGS; i++) tag_q[i] <= '0;
        end else begin
            ready_q <= ready_d;
            wait_q  <= wait_d;
            for (int i = 0; i < NUM_PREGS; i++) tag_q[i] <= tag_d[i];
        end
    end

    // Flatten outputs for the read multiplexers.
    always_comb begin
        ready_vec = ready_q;
        wait_vec  = wait_q;
        for (int i = 0; i < NUM_PREGS; i++) tag_flat[i*VEC_W +: VEC_W] = tag_q[i];
    end

    // R2: a miss marks its register waiting with the miss tag.
    p_miss_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> wait_q[$past(miss_preg)] && (tag_q[$past(miss_preg)] == $past(miss_vec)));

    // R5: a divert marks the destination waiting with the divert tag.
    p_divert_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_set && !(miss_valid && miss_preg == div_preg)
        |=> wait_q[$past(div_preg)] && (tag_q[$past(div_preg)] == $past(div_vec)));

    // R8: completion makes the register ready and not waiting.
    p_fill_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && !(miss_valid && miss_preg == fill_preg) && !(div_set && div_preg == fill_preg)
        |=> ready_q[$past(fill_preg)] && !wait_q[$past(fill_preg)]);

    // R9: reinsertion keeps the ready flag when nothing else touches it.
    p_reins_keeps_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reins_valid && !(alloc_valid && alloc_preg == reins_preg)
        && !(wb_valid && wb_preg == reins_preg) && !(fill_valid && fill_preg == reins_preg)
        |=> ready_q[$past(reins_preg)] == $past(ready_q[reins_preg]));

    // R10: allocation alone leaves a register not ready and not waiting.
    p_alloc_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid && !(wb_valid && wb_preg == alloc_preg) && !(fill_valid && fill_preg == alloc_preg)
        && !(miss_valid && miss_preg == alloc_preg) && !(div_set && div_preg == alloc_preg)
        |=> !ready_q[$past(alloc_preg)] && !wait_q[$past(alloc_preg)]);
endmodule

// File: rtl/wsb_read_mux.sv
// One combinational read of a register's ready, waiting and tag fields.
// Assumes: the select is always below NUM_PREGS.
module wsb_read_mux #(
    parameter int NUM_PREGS = 64,
    parameter int VEC_W     = 3,
    localparam int PREG_W   = $clog2(NUM_PREGS)
) (
    input  logic [NUM_PREGS-1:0]       ready_vec,
    input  logic [NUM_PREGS-1:0]       wait_vec,
    input  logic [NUM_PREGS*VEC_W-1:0] tag_flat,
    input  logic [PREG_W-1:0]          sel,
    output logic                       ready,
    output logic                       waiting,
    output logic [VEC_W-1:0]           tag
);
    // Index the flattened state by the selected register.
    always_comb begin
        ready   = ready_vec[sel];
        waiting = wait_vec[sel];
        tag     = tag_flat[sel*VEC_W +: VEC_W];
    end
endmodule

// File: rtl/wsb_pretend_eval.sv
// Classifies the candidate's sources and derives request, pretend-ready
// and the tag of the first waiting source in ascending source order.
// Assumes: a disabled source never holds the candidate back.
module wsb_pretend_eval
    import wsb_pkg::*;
#(
    parameter int NUM_SRC = 2,
    parameter int VEC_W   = 3
) (
    input  logic [NUM_SRC-1:0]       src_en,
    input  logic [NUM_SRC-1:0]       src_ready,
    input  logic [NUM_SRC-1:0]       src_wait,
    input  logic [NUM_SRC*VEC_W-1:0] src_tag,
    output logic                     all_ready,
    output logic                     pretend,
    output logic [VEC_W-1:0]         first_tag
);
    src_state_e           st [NUM_SRC];
    logic [NUM_SRC-1:0]   is_ready, is_wait, is_blocked;

    // Per-source classification.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        always_comb begin
            if (!src_en[s] || src_ready[s]) st[s] = SRC_READY;
            else if (src_wait[s])            st[s] = SRC_WAITING;
            else                             st[s] = SRC_BLOCKED;
            is_ready[s]   = (st[s] == SRC_READY);
            is_wait[s]    = (st[s] == SRC_WAITING);
            is_blocked[s] = (st[s] == SRC_BLOCKED);
        end
    end

    // Combine sources; walk downward so the lowest waiting source wins.
    always_comb begin
        all_ready = &is_ready;
        pretend   = !(|is_blocked) && (|is_wait);
        first_tag = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (is_wait[s]) first_tag = src_tag[s*VEC_W +: VEC_W];
        end
    end
endmodule

// File: rtl/miss_wait_scoreboard.sv
// Top: per-register waiting-on-miss scoreboard with rename read ports,
// pretend-ready evaluation of one issue candidate and the divert decision.
// Assumes: select grants only a candidate whose cand_req is high.
module miss_wait_scoreboard #(
    parameter int NUM_PREGS = 64,
    parameter int MISS_VECS = 8,
    parameter int NUM_RD    = 4,
    parameter int NUM_SRC   = 2,
    localparam int PREG_W   = $clog2(NUM_PREGS),
    localparam int VEC_W    = $clog2(MISS_VECS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_valid,
    input  logic [PREG_W-1:0]          alloc_preg,
    input  logic                       wb_valid,
    input  logic [PREG_W-1:0]          wb_preg,
    input  logic                       miss_valid,
    input  logic [PREG_W-1:0]          miss_preg,
    input  logic [VEC_W-1:0]           miss_vec,
    input  logic                       fill_valid,
    input  logic [PREG_W-1:0]          fill_preg,
    input  logic                       reins_valid,
    input  logic [PREG_W-1:0]          reins_preg,
    input  logic [NUM_RD*PREG_W-1:0]   rd_preg,
    output logic [NUM_RD-1:0]          rd_ready,
    output logic [NUM_RD-1:0]          rd_wait,
    output logic [NUM_RD*VEC_W-1:0]    rd_vec,
    input  logic [NUM_SRC-1:0]         cand_src_en,
    input  logic [NUM_SRC*PREG_W-1:0]  cand_src_preg,
    input  logic                       cand_dst_en,
    input  logic [PREG_W-1:0]          cand_dst_preg,
    input  logic                       cand_grant,
    output logic                       cand_req,
    output logic                       cand_pretend,
    output logic                       divert,
    output logic [VEC_W-1:0]           divert_vec
);
    logic [NUM_PREGS-1:0]       ready_vec, wait_vec;
    logic [NUM_PREGS*VEC_W-1:0] tag_flat;
    logic [NUM_SRC-1:0]         s_ready, s_wait;
    logic [NUM_SRC*VEC_W-1:0]   s_tag;
    logic                       all_ready, pretend, div_set;
    logic [VEC_W-1:0]           first_tag;

    wsb_entry_array #(.NUM_PREGS(NUM_PREGS), .VEC_W(VEC_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_preg(alloc_preg),
        .wb_valid(wb_valid), .wb_preg(wb_preg),
        .miss_valid(miss_valid), .miss_preg(miss_preg), .miss_vec(miss_vec),
        .fill_valid(fill_valid), .fill_preg(fill_preg),
        .reins_valid(reins_valid), .reins_preg(reins_preg),
        .div_set(div_set), .div_preg(cand_dst_preg), .div_vec(first_tag),
        .ready_vec(ready_vec), .wait_vec(wait_vec), .tag_flat(tag_flat)
    );

    // Rename read ports.
    for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
        wsb_read_mux #(.NUM_PREGS(NUM_PREGS), .VEC_W(VEC_W)) u_rd (
            .ready_vec(ready_vec), .wait_vec(wait_vec), .tag_flat(tag_flat),
            .sel(rd_preg[k*PREG_W +: PREG_W]),
            .ready(rd_ready[k]), .waiting(rd_wait[k]), .tag(rd_vec[k*VEC_W +: VEC_W])
        );
    end

    // Candidate source lookups.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        wsb_read_mux #(.NUM_PREGS(NUM_PREGS), .VEC_W(VEC_W)) u_src (
            .ready_vec(ready_vec), .wait_vec(wait_vec), .tag_flat(tag_flat),
            .sel(cand_src_preg[s*PREG_W +: PREG_W]),
            .ready(s_ready[s]), .waiting(s_wait[s]), .tag(s_tag[s*VEC_W +: VEC_W])
        );
    end

    wsb_pretend_eval #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_eval (
        .src_en(cand_src_en), .src_ready(s_ready), .src_wait(s_wait), .src_tag(s_tag),
        .all_ready(all_ready), .pretend(pretend), .first_tag(first_tag)
    );

    // Divert decision and destination propagation.
    always_comb begin
        cand_req     = all_ready || pretend;
        cand_pretend = pretend && !all_ready;
        divert       = cand_grant && cand_pretend;
        divert_vec   = first_tag;
        div_set      = divert && cand_dst_en;
    end

    // R6: a divert always names a source the storage holds as waiting.
    p_divert_src_waiting_r6: assert property (@(posedge clk) disable iff (!rst_n)
        divert |-> |(cand_src_en & s_wait & ~s_ready));

    // R4: a grant is only given to a requesting candidate (input contract).
    p_grant_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cand_grant |-> cand_req);
endmodule

// File: tb/miss_wait_scoreboard_test.sv
module miss_wait_scoreboard_test;
    localparam int NP = 64, NV = 8, NR = 4, NS = 2;
    localparam int PW = $clog2(NP), VW = $clog2(NV);

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic alloc_valid, wb_valid, miss_valid, fill_valid, reins_valid;
    logic [PW-1:0] alloc_preg, wb_preg, miss_preg, fill_preg, reins_preg, cand_dst_preg;
    logic [VW-1:0] miss_vec, divert_vec;
    logic [NR*PW-1:0] rd_preg;
    logic [NR-1:0] rd_ready, rd_wait;
    logic [NR*VW-1:0] rd_vec;
    logic [NS-1:0] cand_src_en;
    logic [NS*PW-1:0] cand_src_preg;
    logic cand_dst_en, cand_grant, cand_req, cand_pretend, divert;

    miss_wait_scoreboard uut (.*);

    int checks = 0, fails = 0;
    bit m_ready [NP];
    bit m_wait  [NP];
    logic [VW-1:0] m_tag [NP];
    bit e_req, e_pre;
    logic [VW-1:0] e_tag;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; wb_valid = 0; miss_valid = 0; fill_valid = 0; reins_valid = 0;
        alloc_preg = 0; wb_preg = 0; miss_preg = 0; fill_preg = 0; reins_preg = 0; miss_vec = 0;
        cand_src_en = 0; cand_src_preg = 0; cand_dst_en = 0; cand_dst_preg = 0; cand_grant = 0;
        rd_preg = 0;
    endtask

    // Reference classification from R3 and R6.
    function automatic void model_eval();
        bit blocked = 0, anyw = 0, allr = 1;
        e_tag = 0;
        for (int s = NS - 1; s >= 0; s--) begin
            int p = int'(cand_src_preg[s*PW +: PW]);
            if (cand_src_en[s] && !m_ready[p]) begin
                allr = 0;
                if (m_wait[p]) begin anyw = 1; e_tag = m_tag[p]; end
                else blocked = 1;
            end
        end
        e_pre = !allr && anyw && !blocked;
        e_req = allr || e_pre;
    endfunction

    // Reference update from R2, R5, R8-R11.
    function automatic void model_step();
        bit dset = cand_grant && e_pre && cand_dst_en;
        bit nr [NP]; bit nw [NP]; logic [VW-1:0] nt [NP];
        for (int i = 0; i < NP; i++) begin
            bit ha = alloc_valid && alloc_preg == PW'(i), hw = wb_valid && wb_preg == PW'(i);
            bit hm = miss_valid && miss_preg == PW'(i), hf = fill_valid && fill_preg == PW'(i);
            bit hr = reins_valid && reins_preg == PW'(i), hd = dset && cand_dst_preg == PW'(i);
            nr[i] = (hw || hf) ? 1'b1 : ha ? 1'b0 : m_ready[i];
            nw[i] = (hm || hd) ? 1'b1 : (hf || hr || ha) ? 1'b0 : m_wait[i];
            nt[i] = hm ? miss_vec : hd ? e_tag : m_tag[i];
        end
        for (int i = 0; i < NP; i++) begin m_ready[i] = nr[i]; m_wait[i] = nw[i]; m_tag[i] = nt[i]; end
    endfunction

    // Check combinational outputs against the model, then commit the model.
    task automatic step(input string rq);
        #1;
        model_eval();
        for (int k = 0; k < NR; k++) begin
            int p = int'(rd_preg[k*PW +: PW]);
            chk(rd_ready[k] == m_ready[p], {rq, " R7 ready"}, rd_ready[k], m_ready[p]);
            chk(rd_wait[k] == m_wait[p], {rq, " R7 wait"}, rd_wait[k], m_wait[p]);
            chk(rd_vec[k*VW +: VW] == m_tag[p], {rq, " R7 tag"}, rd_vec[k*VW +: VW], m_tag[p]);
        end
        chk(cand_req == e_req, {rq, " R3 req"}, cand_req, e_req);
        chk(cand_pretend == e_pre, {rq, " R3 pretend"}, cand_pretend, e_pre);
        chk(divert == (cand_grant && e_pre), {rq, " R4 divert"}, divert, cand_grant && e_pre);
        if (divert) chk(divert_vec == e_tag, {rq, " R6 tag"}, divert_vec, e_tag);
        model_step();
        @(negedge clk);
        idle();
    endtask

    task automatic look(input int p);
        rd_preg[0 +: PW] = PW'(p);
    endtask

    initial begin
        idle();
        for (int i = 0; i < NP; i++) begin m_ready[i] = 1; m_wait[i] = 0; m_tag[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: scan every register after reset.
        for (int b = 0; b < NP / NR; b++) begin
            for (int k = 0; k < NR; k++) rd_preg[k*PW +: PW] = PW'(b*NR + k);
            step("R1 reset");
        end
        // Chain: p5 misses with tag 3; p6 depends on p5; p9 on p6.
        alloc_valid = 1; alloc_preg = 5; step("R10 alloc");
        alloc_valid = 1; alloc_preg = 6; look(5); step("R10 alloc read");
        miss_valid = 1; miss_preg = 5; miss_vec = 3; step("R2 miss");
        alloc_valid = 1; alloc_preg = 9; look(5); step("R2 readback");
        cand_src_en = 2'b01; cand_src_preg = {PW'(0), PW'(5)};
        cand_dst_en = 1; cand_dst_preg = 6; cand_grant = 1; step("R4 divert");
        look(6); cand_src_en = 2'b10; cand_src_preg = {PW'(6), PW'(0)};
        cand_dst_en = 1; cand_dst_preg = 9; cand_grant = 1; step("R5 transitive");
        look(9); step("R5 readback");
        // R6: two waiting sources on different misses, both orders.
        alloc_valid = 1; alloc_preg = 7; step("R10 alloc");
        miss_valid = 1; miss_preg = 7; miss_vec = 1; step("R2 miss");
        cand_src_en = 2'b11; cand_src_preg = {PW'(5), PW'(7)}; cand_grant = 1; step("R6 order a");
        cand_src_en = 2'b11; cand_src_preg = {PW'(7), PW'(5)}; cand_grant = 1; step("R6 order b");
        // R3: one waiting plus one blocked source cannot request.
        alloc_valid = 1; alloc_preg = 12; step("R10 alloc");
        cand_src_en = 2'b11; cand_src_preg = {PW'(12), PW'(5)}; step("R3 blocked");
        // R4: truly ready grant changes nothing on its destination.
        cand_src_en = 2'b11; cand_src_preg = {PW'(1), PW'(2)};
        cand_dst_en = 1; cand_dst_preg = 12; cand_grant = 1; step("R4 normal grant");
        look(12); step("R4 readback");
        // R11: reinsertion clear and divert set on one register together.
        cand_src_en = 2'b01; cand_src_preg = {PW'(0), PW'(7)};
        cand_dst_en = 1; cand_dst_preg = 9; cand_grant = 1; reins_valid = 1; reins_preg = 9;
        step("R11 set wins");
        look(9); step("R11 readback");
        // R9: reinsertion alone clears waiting, keeps tag and ready.
        reins_valid = 1; reins_preg = 9; step("R9 reins");
        look(9); step("R9 readback");
        // R8: completion.
        fill_valid = 1; fill_preg = 5; step("R8 fill");
        look(5); step("R8 readback");
        // R11: allocation and writeback on one register.
        alloc_valid = 1; alloc_preg = 20; wb_valid = 1; wb_preg = 20; step("R11 ready");
        look(20); step("R11 readback");
        // Random mix over a small register window to force collisions.
        void'($urandom(32'd4242));
        for (int n = 0; n < 4000; n++) begin
            alloc_valid = ($urandom % 4) == 0; alloc_preg = PW'($urandom % 16);
            wb_valid    = ($urandom % 4) == 0; wb_preg    = PW'($urandom % 16);
            miss_valid  = ($urandom % 5) == 0; miss_preg  = PW'($urandom % 16);
            miss_vec    = VW'($urandom);
            fill_valid  = ($urandom % 6) == 0; fill_preg  = PW'($urandom % 16);
            reins_valid = ($urandom % 6) == 0; reins_preg = PW'($urandom % 16);
            for (int k = 0; k < NR; k++) rd_preg[k*PW +: PW] = PW'($urandom % 16);
            cand_src_en = NS'($urandom);
            for (int s = 0; s < NS; s++) cand_src_preg[s*PW +: PW] = PW'($urandom % 16);
            cand_dst_en = 1'($urandom); cand_dst_preg = PW'($urandom % 16);
            model_eval();
            cand_grant = e_req && (($urandom % 3) != 0);
            step("R3 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule